// File: doc/BRIEF.md
# I2C Master Byte Receiver with Acknowledge Wait States

This engine runs the receive side of an I2C master once the bus is already owned. A host starts each byte by pulsing a read strobe on the data register. The first strobe after entering receive mode is a dummy read: its returned value is stale, and its only purpose is to start the bus. The engine then generates eight SCL clocks. It samples SDA in the middle of every high phase and assembles the byte MSB first. The finished byte lands in the data register when the eighth bit is sampled.

The interrupt flag has two timings. With wait mode on, the flag rises as the eighth clock falls, and SCL stays low until the host clears the flag. This gives software time to choose ACK or NACK for the byte. With wait mode off, no stretch occurs, and the flag rises when the ninth clock goes high.

After the ninth clock, SCL stays low and SDA is released until the host either reads again (the next byte) or asks for a stop. A stop is only honoured when the flag is clear. The stop drives SDA low under a low SCL, releases SCL, and then releases SDA, and the busy status drops at that final edge. Both bus lines are open-drain and are modelled as pull-low enables. SDA comes back through a two-stage synchronizer.

Top module: `i2c_mrx`

## Requirements
- R1: After reset, both pull-low enables are 0, the flag is 0, busy is 0 and the data register reads 0x00.
- R2: A read strobe while idle or holding after a byte starts a byte. Each of the eight bits is SCL pulled low for PHASE_CYC clocks and then released for PHASE_CYC clocks. A start from idle sets busy.
- R3: SDA (through a two-stage synchronizer) is sampled PHASE_CYC/2 clocks into each high phase, MSB first. The data register changes only at the eighth sample and then holds the complete byte.
- R4: With wait mode on, the flag sets at the end of the eighth high phase, and SCL stays pulled low for as long as the flag stays set.
- R5: In the wait state, the ninth clock's low phase begins one clock after the flag reads clear.
- R6: The ack control is captured when the ninth clock's low phase begins. A value of 0 pulls SDA low for the whole ninth clock (ACK), and 1 leaves SDA released (NACK). SDA enables change only while SCL is pulled low, except for the stop release.
- R7: With wait mode off, SCL is not stretched, and the flag sets at the edge where the ninth clock's SCL is released.
- R8: After the ninth clock, SCL stays pulled low and SDA is released until the next read strobe, so bytes can follow back to back.
- R9: A stop request while holding with the flag clear gives PHASE_CYC clocks of SDA and SCL low, then PHASE_CYC clocks of SCL released with SDA low, then SDA released. Busy drops on that last edge.
- R10: A stop request has no effect while the flag is set or while idle.
- R11: A clear that coincides with a flag-set event loses, so the flag reads 1 for at least one clock. Otherwise a clear drops the flag on the next edge.
- R12: Read strobes during a byte, ack or wait phase have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_i | input | 1 | Data register read strobe (starts next byte) |
| wait_en_i | input | 1 | Wait mode enable |
| ack_sel_i | input | 1 | Acknowledge value, 0 = ACK, 1 = NACK |
| flag_clr_i | input | 1 | Clear interrupt flag |
| stop_i | input | 1 | Stop request (direction to transmit with busy written 0) |
| sda_i | input | 1 | SDA line level |
| data_o | output | 8 | Receive data register |
| flag_o | output | 1 | Interrupt flag |
| busy_o | output | 1 | Bus busy status |
| scl_oe_o | output | 1 | SCL pull-low enable |
| sda_oe_o | output | 1 | SDA pull-low enable |

## Verification
The bench targets the handover from wait mode to no-wait mode inside the final byte. A design that latched the mode at the start of the byte would miss the flag at the ninth rising edge and strand the host. A stop issued while the flag is still set would chop the bus in a design that skips the flag gate. A clear held across a set event checks that no flag edge is swallowed. A mid-byte read strobe checks that a design restarting on any read would not corrupt the bit count. Multi-byte runs with distinct patterns check that the data register never shows a half-shifted byte, and that the ACK/NACK choice lands on the ninth clock rather than on the clock before or after it.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_LOW   = 4'd1,
        ST_HIGH  = 4'd2,
        ST_WAIT  = 4'd3,
        ST_ALOW  = 4'd4,
        ST_AHIGH = 4'd5,
        ST_HOLD  = 4'd6,
        ST_SLOW  = 4'd7,
        ST_SHIGH = 4'd8
    } mrx_state_e;

    typedef struct packed {
        logic scl_oe;
        logic sda_oe;
    } pin_drive_t;

    // pull-low enables implied by a state
    function automatic pin_drive_t drive_for(mrx_state_e s, logic nack);
        pin_drive_t d;
        d.scl_oe = (s == ST_LOW) || (s == ST_WAIT) || (s == ST_ALOW) ||
                   (s == ST_HOLD) || (s == ST_SLOW);
        d.sda_oe = (((s == ST_ALOW) || (s == ST_AHIGH)) && !nack) ||
                   (s == ST_SLOW) || (s == ST_SHIGH);
        return d;
    endfunction

    // states whose length is set by the phase timer
    function automatic logic is_timed(mrx_state_e s);
        return (s == ST_LOW) || (s == ST_HIGH) || (s == ST_ALOW) ||
               (s == ST_AHIGH) || (s == ST_SLOW) || (s == ST_SHIGH);
    endfunction

endpackage

// File: rtl/i2c_mrx_sync.sv
module i2c_mrx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{RESET_VAL}};
        else     pipe <= {pipe[STAGES-2:0], d_i};
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/i2c_mrx_phase_timer.sv
module i2c_mrx_phase_timer #(
    parameter int PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic mid_o,
    output logic last_o
);
    localparam int CW = $clog2(PHASE_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt <= '0;
        else              cnt <= cnt + CW'(1);
    end

    assign mid_o  = (cnt == CW'(PHASE_CYC / 2));
    assign last_o = (cnt == CW'(PHASE_CYC - 1));
endmodule

// File: rtl/i2c_mrx_shreg.sv
module i2c_mrx_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_i,
    input  logic         final_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);
    logic [W-1:0] sh;
    logic [W-1:0] sh_n;

    assign sh_n = {sh[W-2:0], bit_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            data_o <= '0;
        end else if (shift_i) begin
            sh <= sh_n;
            if (final_i) data_o <= sh_n;
        end
    end
endmodule

// File: rtl/i2c_mrx.sv
module i2c_mrx
    import i2c_mrx_pkg::*;
#(
    parameter int PHASE_CYC = 4,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_i,
    input  logic                 wait_en_i,
    input  logic                 ack_sel_i,
    input  logic                 flag_clr_i,
    input  logic                 stop_i,
    input  logic                 sda_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 flag_o,
    output logic                 busy_o,
    output logic                 scl_oe_o,
    output logic                 sda_oe_o
);
    localparam int BW = $clog2(DATA_BITS);

    mrx_state_e  st_q, st_n;
    logic [BW-1:0] bit_q, bit_n;
    logic        flag_q, busy_q, nack_q;
    logic        flag_set, ack_cap, busy_set, busy_clr, sample;
    logic        t_mid, t_last, sda_s, last_bit;
    pin_drive_t  pins;

    i2c_mrx_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d_i(sda_i), .q_o(sda_s)
    );

    i2c_mrx_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk(clk), .rst(rst),
        .clr_i((st_n != st_q) || !is_timed(st_q)),
        .mid_o(t_mid), .last_o(t_last)
    );

    i2c_mrx_shreg #(.W(DATA_BITS)) u_shreg (
        .clk(clk), .rst(rst), .shift_i(sample), .final_i(last_bit),
        .bit_i(sda_s), .data_o(data_o)
    );

    assign last_bit = (bit_q == BW'(DATA_BITS - 1));

    always_comb begin
        st_n     = st_q;
        bit_n    = bit_q;
        flag_set = 1'b0;
        ack_cap  = 1'b0;
        busy_set = 1'b0;
        busy_clr = 1'b0;
        sample   = 1'b0;
        case (st_q)
            ST_IDLE: if (rd_i) begin
                st_n = ST_LOW; bit_n = '0; busy_set = 1'b1;
            end
            ST_HOLD: if (rd_i) begin
                st_n = ST_LOW; bit_n = '0;
            end else if (stop_i && !flag_q) begin
                st_n = ST_SLOW;
            end
            ST_LOW: if (t_last) st_n = ST_HIGH;
            ST_HIGH: begin
                sample = t_mid;
                if (t_last) begin
                    if (!last_bit) begin
                        st_n = ST_LOW; bit_n = bit_q + BW'(1);
                    end else if (wait_en_i) begin
                        st_n = ST_WAIT; flag_set = 1'b1;
                    end else begin
                        st_n = ST_ALOW; ack_cap = 1'b1;
                    end
                end
            end
            ST_WAIT: if (!flag_q) begin
                st_n = ST_ALOW; ack_cap = 1'b1;
            end
            ST_ALOW: if (t_last) begin
                st_n = ST_AHIGH; flag_set = !wait_en_i;
            end
            ST_AHIGH: if (t_last) st_n = ST_HOLD;
            ST_SLOW:  if (t_last) st_n = ST_SHIGH;
            ST_SHIGH: if (t_last) begin
                st_n = ST_IDLE; busy_clr = 1'b1;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            bit_q  <= '0;
            flag_q <= 1'b0;
            busy_q <= 1'b0;
            nack_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            bit_q <= bit_n;
            if (flag_set)        flag_q <= 1'b1;
            else if (flag_clr_i) flag_q <= 1'b0;
            if (busy_set)        busy_q <= 1'b1;
            else if (busy_clr)   busy_q <= 1'b0;
            if (ack_cap)         nack_q <= ack_sel_i;
        end
    end

    assign pins     = drive_for(st_q, nack_q);
    assign scl_oe_o = pins.scl_oe;
    assign sda_oe_o = pins.sda_oe;
    assign flag_o   = flag_q;
    assign busy_o   = busy_q;
endmodule

// File: rtl/i2c_mrx_chk.sv
module i2c_mrx_chk
    import i2c_mrx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input mrx_state_e           st,
    input logic [DATA_BITS-1:0] data_o,
    input logic                 flag_o,
    input logic                 busy_o,
    input logic                 scl_oe_o,
    input logic                 sda_oe_o
);
    AST_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && flag_o) |=> scl_oe_o);  // R4

    AST_FLAG_RISE_POINT: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> (st == ST_WAIT || st == ST_AHIGH));  // R7

    AST_DATA_ONLY_AT_LAST: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_o) |-> ($past(st) == ST_HIGH));  // R3

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !$stable(sda_oe_o)) |-> scl_oe_o);  // R6

    AST_STOP_RISE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (!scl_oe_o && !sda_oe_o && $past(sda_oe_o) && !$past(scl_oe_o)));  // R9

    AST_STOP_GATED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SLOW && $past(st) == ST_HOLD) |-> !$past(flag_o));  // R10
endmodule

bind i2c_mrx i2c_mrx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk(clk), .rst(rst), .st(st_q), .data_o(data_o), .flag_o(flag_o),
    .busy_o(busy_o), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
);

// File: tb/i2c_mrx_tb.sv
module i2c_mrx_tb;
    localparam int H = 4;

    logic clk = 1'b0;
    logic rst, rd_i, wait_en_i, ack_sel_i, flag_clr_i, stop_i;
    logic [7:0] data_o;
    logic flag_o, busy_o, scl_oe_o, sda_oe_o;
    logic slave_bit = 1'b1;
    logic sda_i;
    logic [7:0] cur_byte = 8'h00;
    string cur_req = "R1";
    int vectors = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign sda_i = slave_bit & ~sda_oe_o;

    i2c_mrx #(.PHASE_CYC(H), .DATA_BITS(8)) u_dut (
        .clk(clk), .rst(rst), .rd_i(rd_i), .wait_en_i(wait_en_i),
        .ack_sel_i(ack_sel_i), .flag_clr_i(flag_clr_i), .stop_i(stop_i),
        .sda_i(sda_i), .data_o(data_o), .flag_o(flag_o), .busy_o(busy_o),
        .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
    );

    // behavioural reference: 0 idle, 1 data bits, 2 wait, 3 ninth clock, 4 hold, 5 stop
    int m_mode, m_t, m_bit;
    bit m_flag, m_busy, m_ack;
    logic [7:0] m_data, m_sh;

    always @(posedge clk) begin
        int nxt;
        bit set, restart;
        if (rst) begin
            m_mode = 0; m_t = 0; m_bit = 0; m_flag = 0; m_busy = 0;
            m_ack = 0; m_data = 0; m_sh = 0;
        end else begin
            nxt = m_mode; set = 0; restart = 0;
            case (m_mode)
                0, 4: begin
                    if (rd_i) begin
                        nxt = 1; m_bit = 0; restart = 1;
                        if (m_mode == 0) m_busy = 1;
                    end else if (m_mode == 4 && stop_i && !m_flag) nxt = 5;
                end
                1: begin
                    if (m_t == H + H / 2) begin
                        m_sh = {m_sh[6:0], cur_byte[7 - m_bit]};
                        if (m_bit == 7) m_data = m_sh;
                    end
                    if (m_t == 2 * H - 1) begin
                        if (m_bit < 7) begin m_bit++; restart = 1; end
                        else if (wait_en_i) begin nxt = 2; set = 1; end
                        else begin nxt = 3; m_ack = ack_sel_i; end
                    end
                end
                2: if (!m_flag) begin nxt = 3; m_ack = ack_sel_i; end
                3: begin
                    if (m_t == H - 1 && !wait_en_i) set = 1;
                    if (m_t == 2 * H - 1) nxt = 4;
                end
                5: if (m_t == 2 * H - 1) begin nxt = 0; m_busy = 0; end
                default: nxt = 0;
            endcase
            if (set) m_flag = 1;
            else if (flag_clr_i) m_flag = 0;
            if (restart || nxt != m_mode) m_t = 0; else m_t++;
            m_mode = nxt;
        end
    end

    task automatic cmp(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit e_scl, e_sda;
            e_scl = (m_mode == 1 || m_mode == 3 || m_mode == 5) ? (m_t < H) : (m_mode == 2 || m_mode == 4);
            e_sda = (m_mode == 3 && !m_ack) || m_mode == 5;
            cmp(cur_req, "scl_oe", int'(scl_oe_o), int'(e_scl));
            cmp(cur_req, "sda_oe", int'(sda_oe_o), int'(e_sda));
            cmp(cur_req, "flag", int'(flag_o), int'(m_flag));
            cmp(cur_req, "busy", int'(busy_o), int'(m_busy));
            cmp(cur_req, "data", int'(data_o), int'(m_data));
        end
        slave_bit <= (m_mode == 1) ? cur_byte[7 - m_bit] : 1'b1;
    end

    task automatic pulse_rd();
        @(negedge clk); rd_i = 1; @(negedge clk); rd_i = 0;
    endtask
    task automatic pulse_clr();
        @(negedge clk); flag_clr_i = 1; @(negedge clk); flag_clr_i = 0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0;
    endtask
    task automatic wait_flag();
        for (int i = 0; i < 2000 && !flag_o; i++) @(negedge clk);
    endtask
    task automatic wait_mode(input int md);
        for (int i = 0; i < 2000 && m_mode != md; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int hi_cnt;
        rst = 1; rd_i = 0; wait_en_i = 0; ack_sel_i = 0; flag_clr_i = 0; stop_i = 0;
        repeat (3) @(negedge clk);
        cmp("R1", "scl_oe", int'(scl_oe_o), 0);
        cmp("R1", "sda_oe", int'(sda_oe_o), 0);
        cmp("R1", "flag", int'(flag_o), 0);
        cmp("R1", "busy", int'(busy_o), 0);
        cmp("R1", "data", int'(data_o), 0);
        rst = 0;

        // byte 1: dummy-read start, wait mode, ACK
        cur_req = "R2"; cur_byte = 8'hA5; wait_en_i = 1; ack_sel_i = 0;
        pulse_rd();
        cmp("R2", "busy", int'(busy_o), 1);
        repeat (5) @(negedge clk);
        cur_req = "R12";
        pulse_rd();
        cur_req = "R4";
        wait_flag();
        cmp("R3", "data", int'(data_o), 'hA5);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            cmp("R4", "scl_oe held", int'(scl_oe_o), 1);
        end
        cur_req = "R5";
        pulse_clr();
        @(negedge clk);
        cmp("R5", "scl_oe ack low", int'(scl_oe_o), 1);
        cmp("R6", "sda_oe ACK", int'(sda_oe_o), 1);
        wait_mode(4);
        cmp("R8", "sda released", int'(sda_oe_o), 0);

        // byte 2: back to back, wait turned off inside wait phase, NACK
        cur_req = "R8"; cur_byte = 8'h3C;
        pulse_rd();
        wait_flag();
        cmp("R3", "data", int'(data_o), 'h3C);
        cur_req = "R7";
        @(negedge clk); wait_en_i = 0; ack_sel_i = 1;
        pulse_clr();
        wait_flag();
        cmp("R7", "scl released at flag", int'(scl_oe_o), 0);
        cmp("R6", "sda NACK", int'(sda_oe_o), 0);
        wait_mode(4);
        cur_req = "R10";
        pulse_stop();
        repeat (4) @(negedge clk);
        cmp("R10", "busy kept", int'(busy_o), 1);
        cmp("R10", "scl still held", int'(scl_oe_o), 1);

        // byte 3: clear held high across the set event
        cur_req = "R11"; cur_byte = 8'h81; ack_sel_i = 0;
        @(negedge clk); flag_clr_i = 1;
        pulse_rd();
        hi_cnt = 0;
        for (int i = 0; i < 200 && m_mode != 4; i++) begin
            @(negedge clk);
            if (flag_o) hi_cnt++;
        end
        cmp("R11", "flag high cycles", hi_cnt, 1);
        cmp("R3", "data", int'(data_o), 'h81);
        @(negedge clk); flag_clr_i = 0;
        @(negedge clk);
        cur_req = "R9";
        pulse_stop();
        wait_mode(0);
        @(negedge clk);
        cmp("R9", "busy", int'(busy_o), 0);
        cmp("R9", "sda_oe", int'(sda_oe_o), 0);
        cmp("R9", "scl_oe", int'(scl_oe_o), 0);

        // stop while idle
        cur_req = "R10";
        pulse_stop();
        repeat (4) @(negedge clk);
        cmp("R10", "idle sda", int'(sda_oe_o), 0);
        cmp("R10", "idle busy", int'(busy_o), 0);

        // byte 4 from idle, no wait, ACK
        cur_req = "R2"; cur_byte = 8'h5A;
        pulse_rd();
        cmp("R2", "busy", int'(busy_o), 1);
        cur_req = "R7";
        wait_mode(4);
        cmp("R3", "data", int'(data_o), 'h5A);
        cmp("R7", "flag", int'(flag_o), 1);
        pulse_clr();
        @(negedge clk);
        cur_req = "R9";
        pulse_stop();
        wait_mode(0);
        repeat (3) @(negedge clk);
        cmp("R9", "busy", int'(busy_o), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule